// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block keeps the forwarding-range registers of a PCI-to-PCI bridge and checks each transaction address against the three windows they describe. Configuration software reaches the registers through a small dword-wide port. The port has a dword index, write data, per-byte write enables, and read data that is returned one clock after the index is presented. From the stored fields the block forms an I/O window, a non-prefetchable memory window and a prefetchable memory window.

Each window base is formed by appending zeros below the stored bits, and each limit by appending ones. Only the prefetchable window carries an upper 32-bit extension, so it is the only window that can cover addresses above 4 GiB. The I/O window takes a 16-bit upper extension. The non-prefetchable window is limited to the low 4 GiB.

For every incoming address and transaction type, the block reports the matching window combinationally. At most one window is reported, so the bridge can decide whether to claim the transaction and pass it downstream.

Top module: `bridge_window_decoder`

## Requirements
- R1: After a synchronous reset every stored register bit is zero and `cfg_rdata` is zero.
- R2: `cfg_rdata` returns, one clock after `cfg_dw_addr` is presented, the dword at that index. The map is:
  - index 7: I/O base in bits 7:0 and I/O limit in bits 15:8.
  - index 8: non-prefetchable base in bits 15:0 and limit in bits 31:16.
  - index 9: prefetchable base in bits 15:0 and limit in bits 31:16.
  - index 10: prefetchable base upper 32 bits.
  - index 11: prefetchable limit upper 32 bits.
  - index 12: I/O base upper 16 bits in bits 15:0 and I/O limit upper 16 bits in bits 31:16.
  - Any other index reads zero and ignores writes.
- R3: Only these bits are writable: bits 7:4 and 15:12 of index 7; bits 15:4 and 31:20 of indices 8 and 9; all bits of indices 10, 11 and 12. Every other bit reads zero, whatever was written.
- R4: A write changes only the byte lanes whose `cfg_be` bit is set. A write with `cfg_be` = 0 changes nothing.
- R5: The I/O window runs from {io_up_base, iobase[7:4], 12'h000} to {io_up_limit, iolimit[7:4], 12'hFFF}, where these are 32-bit addresses.
- R6: The non-prefetchable window runs from {npbase[15:4], 20'h00000} to {nplimit[15:4], 20'hFFFFF}. A memory address with any of bits 63:32 set never matches it.
- R7: The prefetchable window runs from {pf_up_base, pfbase[15:4], 20'h00000} to {pf_up_limit, pflimit[15:4], 20'hFFFFF}, over the full 64-bit address.
- R8: A window matches when base <= address <= limit, using an unsigned compare that includes both ends. A window whose base is greater than its limit never matches.
- R9: `hit_io` can assert only when `txn_is_io` = 1 and bits 63:32 of the address are zero. `hit_np` and `hit_pf` can assert only when `txn_is_io` = 0.
- R10: When a memory address lies in both memory windows, only `hit_pf` asserts. At most one hit output is ever high.
- R11: The hit outputs are combinational from `txn_addr` and `txn_is_io`. After a register write, they reflect the new value from the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_dw_addr | input | 6 | Dword index of the register access |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte-lane write enables |
| cfg_rdata | output | 32 | Read data, registered |
| txn_addr | input | 64 | Transaction address to decode |
| txn_is_io | input | 1 | 1 = I/O transaction, 0 = memory transaction |
| hit_io | output | 1 | Address falls in the I/O window |
| hit_np | output | 1 | Address falls in the non-prefetchable window |
| hit_pf | output | 1 | Address falls in the prefetchable window |

## Verification
The hardest situations to reach are the ones where two fields interact: the two memory windows overlapping, and a window disabled because its base lies above its limit. Neither occurs with ordinary programming. The stimulus reaches them by rewriting the prefetchable fields to straddle the non-prefetchable range, then probing addresses inside both windows and inside only one. It then rewrites the non-prefetchable base above its limit and probes addresses that either end alone would have accepted. The edges of every window are probed one address inside and one address outside. This includes addresses that differ from a match only in bits 63:32, which tests the upper extensions and the 32-bit limit on the other two windows.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int CFG_W    = 32;
  localparam int BE_W     = CFG_W / 8;
  localparam int DWA_W    = 6;
  localparam int TXN_W    = 64;
  localparam int FIRST_DW = 7;
  localparam int NUM_DW   = 6;
  localparam int NUM_WIN  = 3;

  // slot numbers relative to FIRST_DW
  localparam int S_IO    = 0;
  localparam int S_NP    = 1;
  localparam int S_PF    = 2;
  localparam int S_PFB_U = 3;
  localparam int S_PFL_U = 4;
  localparam int S_IO_U  = 5;

  typedef enum int {WIN_IO = 0, WIN_NP = 1, WIN_PF = 2} win_e;

  function automatic logic [CFG_W-1:0] wr_mask(int slot);
    case (slot)
      S_IO:       wr_mask = 32'h0000_F0F0;
      S_NP, S_PF: wr_mask = 32'hFFF0_FFF0;
      default:    wr_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/bwd_regfile.sv
module bwd_regfile
  import bwd_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr,
  input  logic [DWA_W-1:0]              addr,
  input  logic [CFG_W-1:0]              wdata,
  input  logic [BE_W-1:0]               be,
  output logic [CFG_W-1:0]              rdata,
  output logic [NUM_DW-1:0][CFG_W-1:0]  regs
);
  logic [CFG_W-1:0] lane_m;
  logic [CFG_W-1:0] rd_next;
  logic             mapped;

  always_comb begin
    for (int b = 0; b < BE_W; b++) lane_m[b*8 +: 8] = {8{be[b]}};
  end

  for (genvar s = 0; s < NUM_DW; s++) begin : g_slot
    localparam logic [DWA_W-1:0] IDX = DWA_W'(FIRST_DW + s);
    localparam logic [CFG_W-1:0] WM  = wr_mask(s);
    always_ff @(posedge clk) begin
      if (rst)
        regs[s] <= '0;
      else if (wr && addr == IDX)
        regs[s] <= (regs[s] & ~(lane_m & WM)) | (wdata & lane_m & WM);
    end
  end

  always_comb begin
    rd_next = '0;
    mapped  = 1'b0;
    for (int s = 0; s < NUM_DW; s++) begin
      if (addr == DWA_W'(FIRST_DW + s)) begin
        rd_next = regs[s];
        mapped  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  AST_NO_LANE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (wr && be == '0) |=> $stable(regs)); // R4
  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!mapped) |=> (rdata == '0)); // R2
endmodule

// File: rtl/bwd_window_cmp.sv
module bwd_window_cmp #(
  parameter int W = 64
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] limit,
  input  logic [W-1:0] addr,
  output logic         hit
);
  logic enabled;
  assign enabled = (base <= limit);
  assign hit     = enabled && (addr >= base) && (addr <= limit);
endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
  import bwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [DWA_W-1:0]  cfg_dw_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [BE_W-1:0]   cfg_be,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [TXN_W-1:0]  txn_addr,
  input  logic              txn_is_io,
  output logic              hit_io,
  output logic              hit_np,
  output logic              hit_pf
);
  logic [NUM_DW-1:0][CFG_W-1:0] r;
  logic [TXN_W-1:0]             w_base [NUM_WIN];
  logic [TXN_W-1:0]             w_lim  [NUM_WIN];
  logic [NUM_WIN-1:0]           raw;

  bwd_regfile u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (cfg_wr),
    .addr  (cfg_dw_addr),
    .wdata (cfg_wdata),
    .be    (cfg_be),
    .rdata (cfg_rdata),
    .regs  (r)
  );

  // window edges: zeros appended below the base, ones below the limit
  always_comb begin
    w_base[WIN_IO] = {32'h0, r[S_IO_U][15:0],  r[S_IO][7:4],    12'h000};
    w_lim [WIN_IO] = {32'h0, r[S_IO_U][31:16], r[S_IO][15:12],  12'hFFF};
    w_base[WIN_NP] = {32'h0, r[S_NP][15:4],  20'h00000};
    w_lim [WIN_NP] = {32'h0, r[S_NP][31:20], 20'hFFFFF};
    w_base[WIN_PF] = {r[S_PFB_U], r[S_PF][15:4],  20'h00000};
    w_lim [WIN_PF] = {r[S_PFL_U], r[S_PF][31:20], 20'hFFFFF};
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    bwd_window_cmp #(.W(TXN_W)) u_cmp (
      .base  (w_base[w]),
      .limit (w_lim[w]),
      .addr  (txn_addr),
      .hit   (raw[w])
    );
  end

  assign hit_io = txn_is_io  & raw[WIN_IO];
  assign hit_pf = !txn_is_io & raw[WIN_PF];
  assign hit_np = !txn_is_io & raw[WIN_NP] & !raw[WIN_PF];

  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_io, hit_np, hit_pf})); // R10
  AST_IO_HIT_TYPE: assert property (@(posedge clk) disable iff (rst)
    hit_io |-> (txn_is_io && txn_addr[63:32] == '0)); // R9
  AST_NP_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
    hit_np |-> (!txn_is_io && txn_addr[63:32] == '0)); // R6
  AST_PF_MEM_ONLY: assert property (@(posedge clk) disable iff (rst)
    hit_pf |-> !txn_is_io); // R9
endmodule

// File: tb/bridge_window_decoder_tb.sv
`timescale 1ns/1ps
module bridge_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr;
  logic [5:0]  cfg_dw_addr;
  logic [31:0] cfg_wdata;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_rdata;
  logic [63:0] txn_addr;
  logic        txn_is_io;
  logic        hit_io, hit_np, hit_pf;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  bridge_window_decoder u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_dw_addr(cfg_dw_addr),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
    .txn_addr(txn_addr), .txn_is_io(txn_is_io),
    .hit_io(hit_io), .hit_np(hit_np), .hit_pf(hit_pf)
  );

  // {is_io, address, expected {io, np, pf}}
  localparam int NV = 18;
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 64'h0000_0000_0001_2000, 3'b100},
    {1'b1, 64'h0000_0000_0001_1FFF, 3'b000},
    {1'b1, 64'h0000_0000_0001_3FFF, 3'b100},
    {1'b1, 64'h0000_0000_0001_4000, 3'b000},
    {1'b1, 64'h0000_0001_0001_2000, 3'b000},
    {1'b0, 64'h0000_0000_0001_2000, 3'b000},
    {1'b0, 64'h0000_0000_1230_0000, 3'b010},
    {1'b0, 64'h0000_0000_125F_FFFF, 3'b010},
    {1'b0, 64'h0000_0000_1260_0000, 3'b000},
    {1'b0, 64'h0000_0000_122F_FFFF, 3'b000},
    {1'b0, 64'h0000_0001_1230_0000, 3'b000},
    {1'b0, 64'h0000_0001_8000_0000, 3'b001},
    {1'b0, 64'h0000_0001_7FFF_FFFF, 3'b000},
    {1'b0, 64'h0000_0002_801F_FFFF, 3'b001},
    {1'b0, 64'h0000_0002_8020_0000, 3'b000},
    {1'b0, 64'h0000_0001_9000_0000, 3'b001},
    {1'b0, 64'h0000_0002_0000_0000, 3'b001},
    {1'b1, 64'h0000_0000_1230_0000, 3'b000}
  };

  task automatic wr_dw(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dw_addr = a; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic chk_rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_dw_addr = a;
    @(posedge clk);
    #1;
    checks++;
    if (cfg_rdata !== exp) begin
      fails++;
      $display("FAIL %s read idx %0d: actual %h expected %h", tag, a, cfg_rdata, exp);
    end
  endtask

  task automatic chk_dec(input string tag, input logic io, input logic [63:0] a,
                         input logic [2:0] exp);
    @(negedge clk);
    txn_is_io = io; txn_addr = a;
    #1;
    checks++;
    if ({hit_io, hit_np, hit_pf} !== exp) begin
      fails++;
      $display("FAIL %s decode io=%0b addr %h: actual %b expected %b",
               tag, io, a, {hit_io, hit_np, hit_pf}, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_wr = 1'b0; cfg_dw_addr = '0; cfg_wdata = '0; cfg_be = '0;
    txn_addr = '0; txn_is_io = 1'b0;
    repeat (3) @(posedge clk);
    #1 checks++;
    if (cfg_rdata !== 32'h0) begin
      fails++;
      $display("FAIL R1 rdata in reset: actual %h expected 0", cfg_rdata);
    end
    @(negedge clk);
    rst = 1'b0;
    // R1: all fields zero -> I/O 0..FFF, both memory windows 0..FFFFF
    chk_rd ("R1", 6'd8, 32'h0);
    chk_rd ("R1", 6'd11, 32'h0);
    chk_dec("R1 R10", 1'b0, 64'h500, 3'b001);
    chk_dec("R1 R5", 1'b1, 64'h800, 3'b100);
    chk_dec("R1 R8", 1'b1, 64'h1000, 3'b000);

    // program windows; junk in read-only bits (R3)
    wr_dw(6'd7,  32'hFFFF_3F2F, 4'hF);
    wr_dw(6'd12, 32'h0001_0001, 4'hF);
    wr_dw(6'd8,  32'h125F_123F, 4'hF);
    wr_dw(6'd9,  32'h801F_800F, 4'hF);
    wr_dw(6'd10, 32'h0000_0001, 4'hF);
    wr_dw(6'd11, 32'h0000_0002, 4'hF);
    chk_rd("R2 R3", 6'd7,  32'h0000_3020);
    chk_rd("R2 R3", 6'd8,  32'h1250_1230);
    chk_rd("R2 R3", 6'd9,  32'h8010_8000);
    chk_rd("R2", 6'd10, 32'h0000_0001);
    chk_rd("R2", 6'd11, 32'h0000_0002);
    chk_rd("R2", 6'd12, 32'h0001_0001);

    // table walk: R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++)
      chk_dec("R5/R6/R7/R8/R9 table", VEC[i][67], VEC[i][66:3], VEC[i][2:0]);

    // unmapped indices (R2)
    wr_dw(6'd3, 32'hFFFF_FFFF, 4'hF);
    chk_rd("R2 unmapped", 6'd3, 32'h0);
    chk_rd("R2 unmapped", 6'd13, 32'h0);
    chk_dec("R2 unmapped write no effect", 1'b0, 64'h0000_0000_1230_0000, 3'b010);

    // overlap: prefetchable 0x1200_0000..0x124F_FFFF inside low 4 GiB (R10, R11)
    wr_dw(6'd10, 32'h0, 4'hF);
    wr_dw(6'd11, 32'h0, 4'hF);
    wr_dw(6'd9,  32'h1240_1200, 4'hF);
    chk_dec("R10 overlap", 1'b0, 64'h0000_0000_1240_0000, 3'b001);
    chk_dec("R10 np only", 1'b0, 64'h0000_0000_1250_0000, 3'b010);
    chk_dec("R11 pf only", 1'b0, 64'h0000_0000_1210_0000, 3'b001);

    // non-prefetchable base above limit: disabled (R8)
    wr_dw(6'd8, 32'h1000_2000, 4'hF);
    chk_dec("R8 disabled", 1'b0, 64'h0000_0000_1250_0000, 3'b000);
    chk_dec("R8 disabled", 1'b0, 64'h0000_0000_2000_0000, 3'b000);
    chk_dec("R8 disabled", 1'b0, 64'h0000_0000_1000_0000, 3'b000);

    // byte lanes (R4)
    wr_dw(6'd10, 32'hAABB_CCDD, 4'b0101);
    chk_rd("R4 lanes", 6'd10, 32'h00BB_00DD);
    wr_dw(6'd10, 32'hFFFF_FFFF, 4'b0000);
    chk_rd("R4 no lanes", 6'd10, 32'h00BB_00DD);
    wr_dw(6'd7, 32'h0000_00F0, 4'b0010);
    chk_rd("R4 R3 lane1", 6'd7, 32'h0000_0020);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule